// File: doc/BRIEF.md
# Word Serializer with Loopback Select

This block turns 10-bit parallel transmission characters into a serial bit stream clocked by a bit-rate clock. A modulo-10 counter in the bit-clock domain paces the conversion and drives a byte-rate clock out to the upstream logic. The upstream logic returns that clock as the transmit clock, and its rising edge captures each parallel word into an input register.

Once every ten bit periods the captured word moves into a shift register. The shift register sends it out most-significant bit first. The serial stream goes to one of two true/complement output pairs: the line pair in normal operation, or the loopback pair when loop-enable is set. The pair that is not selected is parked at true=0, complement=1.

A word presented before a transmit-clock rise starts on the line ten bit periods after that rise. Words captured on consecutive transmit-clock rises leave back to back with no gap.

Top module: `word_serializer`

## Requirements
- R1: The word on `data_i` at a rising edge of `tx_clk_i` is captured and transmitted whole in the following byte period, which starts at the next rising edge of `byte_clk_o`.
- R2: Each word is sent highest bit first: bit 9 in the first bit period after the load, and bit 0 in the tenth.
- R3: With `loop_en_i` = 0 the line pair carries the serial data and the loopback pair is held at true=0, complement=1.
- R4: With `loop_en_i` = 1 the loopback pair carries the serial data and the line pair is held at true=0, complement=1.
- R5: `byte_clk_o` has a period of 10 bit clocks. It rises on the bit-clock edge that loads a word and stays high for the first 5 bit periods of that word.
- R6: The shift register loads exactly once every 10 bit clocks, so consecutive words leave with no gap and no repeated or dropped bit.
- R7: On the active pair the true output carries the current bit and the complement output carries its inverse.
- R8: During reset, and after reset until the first load 10 bit clocks after release, both pairs show true=0, complement=1.
- R9: A change of `loop_en_i` sampled at a bit-clock edge moves the stream to the newly selected pair from that bit onward. It does not disturb the bit order or the word alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_clk_i | input | 1 | Transmit clock, derived upstream from byte_clk_o |
| data_i | input | 10 | Parallel word, bit 9 sent first |
| loop_en_i | input | 1 | 1 routes the stream to the loopback pair |
| byte_clk_o | output | 1 | Byte-rate clock, bit clock divided by 10 |
| line_t_o | output | 1 | Line pair, true output |
| line_c_o | output | 1 | Line pair, complement output |
| lpbk_t_o | output | 1 | Loopback pair, true output |
| lpbk_c_o | output | 1 | Loopback pair, complement output |

## Verification
The assertions take for granted three things about the inputs:
- `tx_clk_i` is `byte_clk_o` fed back with no extra bit-clock delay, so the input register is written just after each load and never at the load edge itself.
- `data_i` is steady across each transmit-clock rise.
- `loop_en_i` changes only between bit-clock edges.

The bench ties the transmit clock directly to the byte clock. It changes the data and the loop select only on falling bit-clock edges, well away from any rising edge.

// File: rtl/word_ser_pkg.sv
package word_ser_pkg;
  localparam int unsigned NUM_LANES = 2;

  typedef enum logic [0:0] {
    LANE_LINE = 1'b0,
    LANE_LOOP = 1'b1
  } lane_e;
endpackage

// File: rtl/word_ser_bit_counter.sv
module word_ser_bit_counter #(
  parameter int unsigned WORD_W = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o,
  output logic byte_clk_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam int unsigned HALF  = WORD_W / 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             byte_clk_q;

  assign load_o = (cnt_q == LAST);
  assign cnt_d  = load_o ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      byte_clk_q <= 1'b1;
    end else begin
      cnt_q      <= cnt_d;
      byte_clk_q <= (cnt_d < CNT_W'(HALF));
    end
  end

  assign byte_clk_o = byte_clk_q;

  assert_cnt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  assert_byte_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byte_clk_q) |-> (cnt_q == '0));

  assert_load_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (cnt_q == '0) && byte_clk_q);
endmodule

// File: rtl/word_ser_shift_unit.sv
module word_ser_shift_unit #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              tx_clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic              load_i,
  output logic              bit_o,
  output logic              active_o
);
  logic [WORD_W-1:0] in_q, shift_q;
  logic              active_q;

  // input register in the transmit clock domain
  always_ff @(posedge tx_clk_i or negedge rst_ni) begin
    if (!rst_ni) in_q <= '0;
    else         in_q <= data_i;
  end

  // MSB leaves first: shift toward the top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q  <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      shift_q  <= in_q;
      active_q <= 1'b1;
    end else begin
      shift_q  <= {shift_q[WORD_W-2:0], 1'b0};
    end
  end

  assign bit_o    = shift_q[WORD_W-1];
  assign active_o = active_q;

  assert_load_word_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (shift_q == $past(in_q)));

  assert_msb_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && active_q) |=> (bit_o == $past(shift_q[WORD_W-2])));

  assert_active_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |=> active_q);
endmodule

// File: rtl/word_ser_lane_steer.sv
module word_ser_lane_steer
  import word_ser_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 loop_en_i,
  input  logic                 bit_i,
  input  logic                 active_i,
  output logic [NUM_LANES-1:0] t_o,
  output logic [NUM_LANES-1:0] c_o
);
  lane_e lane_q;

  // select changes only at a bit boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lane_q <= LANE_LINE;
    else         lane_q <= loop_en_i ? LANE_LOOP : LANE_LINE;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic sel;
    assign sel    = (lane_q == lane_e'(g));
    assign t_o[g] = sel & active_i & bit_i;
    assign c_o[g] = ~t_o[g];

    assert_lane_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      c_o[g] != t_o[g]);
  end

  assert_line_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_q == LANE_LOOP) |-> (!t_o[LANE_LINE] && c_o[LANE_LINE]));

  assert_loop_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_q == LANE_LINE) |-> (!t_o[LANE_LOOP] && c_o[LANE_LOOP]));

  assert_sel_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (lane_q == ($past(loop_en_i) ? LANE_LOOP : LANE_LINE)));
endmodule

// File: rtl/word_serializer.sv
module word_serializer
  import word_ser_pkg::*;
#(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_clk_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              loop_en_i,
  output logic              byte_clk_o,
  output logic              line_t_o,
  output logic              line_c_o,
  output logic              lpbk_t_o,
  output logic              lpbk_c_o
);
  logic                 load;
  logic                 ser_bit;
  logic                 active;
  logic [NUM_LANES-1:0] t_vec, c_vec;

  word_ser_bit_counter #(.WORD_W(WORD_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_o     (load),
    .byte_clk_o (byte_clk_o)
  );

  word_ser_shift_unit #(.WORD_W(WORD_W)) u_shift (
    .clk_i    (clk_i),
    .tx_clk_i (tx_clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .load_i   (load),
    .bit_o    (ser_bit),
    .active_o (active)
  );

  word_ser_lane_steer u_steer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .loop_en_i (loop_en_i),
    .bit_i     (ser_bit),
    .active_i  (active),
    .t_o       (t_vec),
    .c_o       (c_vec)
  );

  assign line_t_o = t_vec[LANE_LINE];
  assign line_c_o = c_vec[LANE_LINE];
  assign lpbk_t_o = t_vec[LANE_LOOP];
  assign lpbk_c_o = c_vec[LANE_LOOP];

  assert_reset_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (!line_t_o && line_c_o && !lpbk_t_o && lpbk_c_o));

  assert_one_pair_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_t_o && lpbk_t_o));
endmodule

// File: tb/word_serializer_tb.sv
module word_serializer_tb_top;
  localparam int unsigned W = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         loop_en_i = 1'b0;
  logic         tx_clk_i;
  logic         byte_clk_o, line_t_o, line_c_o, lpbk_t_o, lpbk_c_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;
  assign tx_clk_i = byte_clk_o;

  word_serializer #(.WORD_W(W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_clk_i(tx_clk_i), .data_i(data_i),
    .loop_en_i(loop_en_i), .byte_clk_o(byte_clk_o), .line_t_o(line_t_o),
    .line_c_o(line_c_o), .lpbk_t_o(lpbk_t_o), .lpbk_c_o(lpbk_c_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pins();
    return {line_t_o, line_c_o, lpbk_t_o, lpbk_c_o};
  endfunction

  // R3/R4/R7: expected pins for a bit on a given pair
  function automatic logic [3:0] exp_pins(input logic b, input logic lp);
    return lp ? {1'b0, 1'b1, b, ~b} : {b, ~b, 1'b0, 1'b1};
  endfunction

  // waits for the load edge, then checks 10 bits MSB first (R2)
  task automatic read_word(input logic [W-1:0] w, input string req,
                           input int sw_at, input logic sw_val);
    logic lp;
    logic [W-1:0] got;
    lp = loop_en_i;
    @(posedge byte_clk_o);
    for (int i = 0; i < W; i++) begin
      @(negedge clk_i);
      got[W-1-i] = lp ? lpbk_t_o : line_t_o;
      check(pins() == exp_pins(w[W-1-i], lp), req, pins(), exp_pins(w[W-1-i], lp));
      if (i == sw_at) begin
        loop_en_i = sw_val;
        lp = sw_val;
      end
    end
    check(got == w, {req, " word"}, got, w);
  endtask

  task automatic send_and_check(input logic [W-1:0] w, input logic lp, input string req);
    loop_en_i = lp;
    @(posedge byte_clk_o);
    @(negedge clk_i);
    data_i = w;
    @(posedge byte_clk_o);
    read_word(w, req, -1, 1'b0);
  endtask

  task automatic t_reset_idle();
    data_i = 10'h3ff;
    @(negedge clk_i);
    check(pins() == 4'b0101, "R8 in reset", pins(), 4'b0101);
    check(byte_clk_o == 1'b1, "R5 reset level", byte_clk_o, 1);
    rst_ni = 1'b1;
    for (int i = 0; i < W - 1; i++) begin
      @(negedge clk_i);
      check(pins() == 4'b0101, "R8 before first load", pins(), 4'b0101);
    end
  endtask

  task automatic t_byte_clk();
    @(posedge byte_clk_o);
    for (int i = 0; i < 2 * W; i++) begin
      @(negedge clk_i);
      check(byte_clk_o == ((i % W) < W / 2), "R5 byte clock shape", byte_clk_o,
            ((i % W) < W / 2));
    end
  endtask

  task automatic t_back_to_back();
    loop_en_i = 1'b0;
    @(posedge byte_clk_o);
    @(negedge clk_i);
    data_i = 10'h2d3;
    @(posedge byte_clk_o);
    @(negedge clk_i);
    data_i = 10'h12c;
    read_word(10'h2d3, "R6 first of pair", -1, 1'b0);
    read_word(10'h12c, "R6 second of pair", -1, 1'b0);
  endtask

  task automatic t_loop_switch();
    loop_en_i = 1'b0;
    @(posedge byte_clk_o);
    @(negedge clk_i);
    data_i = 10'h2b5;
    @(posedge byte_clk_o);
    read_word(10'h2b5, "R9 switch to loopback", 4, 1'b1);
    @(negedge clk_i);
    data_i = 10'h0f1;
    read_word(10'h2b5, "R9 word after switch", 6, 1'b0);
    read_word(10'h0f1, "R9 alignment kept", -1, 1'b0);
  endtask

  initial begin
    t_reset_idle();
    t_byte_clk();
    send_and_check(10'h17c, 1'b0, "R1 R3 line pair");
    send_and_check(10'h283, 1'b1, "R4 loopback pair");
    send_and_check(10'h200, 1'b0, "R2 only msb set");
    send_and_check(10'h001, 1'b1, "R2 only lsb set");
    send_and_check(10'h3ff, 1'b0, "R7 all ones");
    t_back_to_back();
    t_loop_switch();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule